// File: doc/BRIEF.md
# Stream-Commanded Exact-Match Key Table

This block keeps a small table of key/response pairs held in registers. A producer changes or queries the table through a command stream, and the block answers each command on a reply stream. Both streams follow AXI4-Stream valid/ready rules. A command word holds an opcode, a key and a response value. A reply word holds an outcome code and the number of occupied entries after the command has been applied.

The block works on one command at a time. After it accepts a command it lowers command ready and checks the stored entries one per cycle, in index order. It then applies the operation and presents the reply. Command ready rises again only after the reply has been taken. An insert uses the lowest-index free entry. Lookups report only whether the key is present, because the reply format has no field for a response value.

Top module: `kv_cmd_table`

## Requirements
- R1: A command is taken only on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready stays low from that edge until the reply for that command has been taken.
- R2: Command word layout: the opcode is bits [7:0], with 0x00 insert, 0x01 update, 0x02 delete and 0x03 get. The key starts at bit 8 and is padded with zeros to 8·ceil(KEY_W/8) bits. The response value starts at bit 8 + 8·ceil(KEY_W/8) and is padded to whole bytes.
- R3: The reply word is 24 bits. Bits [7:0] hold the status and bits [23:8] hold the fill level, which is the number of occupied entries after the command. The fill level never exceeds DEPTH.
- R4: An insert of an absent key into a table with a free entry returns status 0x00 and raises the fill level by one. An insert of a key that is already stored returns 0x03 and changes nothing. An insert of an absent key into a full table returns 0x01 and changes nothing.
- R5: An update of a stored key returns 0x00 and leaves the fill level unchanged. An update of an absent key returns 0x02.
- R6: A delete of a stored key returns 0x00, frees the entry and lowers the fill level by one. After that, the key reads as absent and its slot can be used again. A delete of an absent key returns 0x02.
- R7: A get returns 0x00 if the key is stored and 0x02 if it is not. A get never changes the table or the fill level.
- R8: A command with any opcode above 0x03 is answered with 0x04 and changes nothing. Codes 0x05 and above are never produced.
- R9: Every accepted command gets exactly one reply. While rpl_valid is high and rpl_ready is low, rpl_valid and rpl_data hold their values.
- R10: After reset the table is empty, the fill level is zero, rpl_valid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command word is valid |
| cmd_ready | output | 1 | Block can take a command |
| cmd_data | input | 8+8·ceil(KEY_W/8)+8·ceil(RSP_W/8) | Opcode, key and response value |
| rpl_valid | output | 1 | Reply word is valid |
| rpl_ready | input | 1 | Downstream takes the reply; may be tied high |
| rpl_data | output | 24 | Status byte and 16-bit fill level |

## Verification
The bench builds the table with DEPTH=4, KEY_W=12 and RSP_W=5. With only four entries, full-table rejection and slot reuse after a delete can be reached within a few commands. The key and response widths are not whole bytes, so the zero padding and the shifted response position are both exercised. Keys that differ only in their top bit check that the whole key is compared. The reply side is run both with ready held high and with ready toggling, which covers back-to-back acceptance as well as reply stalls.

// File: rtl/kvt_pkg.sv
package kvt_pkg;
  localparam int REPLY_W = 24;
  localparam int FILL_W  = 16;

  typedef enum logic [7:0] {
    OPC_INSERT = 8'h00,
    OPC_UPDATE = 8'h01,
    OPC_DELETE = 8'h02,
    OPC_GET    = 8'h03
  } opc_e;

  typedef enum logic [7:0] {
    RES_OK      = 8'h00,
    RES_FULL    = 8'h01,
    RES_MISSING = 8'h02,
    RES_DUP     = 8'h03,
    RES_BUSY    = 8'h04
  } res_e;

  function automatic int byte_span(input int bits);
    return 8 * ((bits + 7) / 8);
  endfunction
endpackage

// File: rtl/kvt_cmd_unpack.sv
module kvt_cmd_unpack
  import kvt_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int RSP_W = 16,
  localparam int KEY_SPAN = byte_span(KEY_W),
  localparam int RSP_POS  = 8 + KEY_SPAN,
  localparam int CMD_W    = 8 + KEY_SPAN + byte_span(RSP_W)
) (
  input  logic [CMD_W-1:0] cmd_word,
  output logic [7:0]       opcode,
  output logic             opcode_known,
  output logic [KEY_W-1:0] key,
  output logic [RSP_W-1:0] rsp
);
  logic unused_pad;

  always_comb begin
    opcode       = cmd_word[7:0];
    opcode_known = (cmd_word[7:2] == 6'd0);
    key          = cmd_word[8 +: KEY_W];
    rsp          = cmd_word[RSP_POS +: RSP_W];
  end

  assign unused_pad = ^cmd_word;
endmodule

// File: rtl/kvt_entry_store.sv
module kvt_entry_store #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 32,
  parameter int RSP_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [RSP_W-1:0] wr_rsp,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [KEY_W-1:0] rd_key,
  output logic [RSP_W-1:0] rd_rsp
);
  logic [DEPTH-1:0]            vld_vec;
  logic [DEPTH-1:0][KEY_W-1:0] key_vec;
  logic [DEPTH-1:0][RSP_W-1:0] rsp_vec;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             v_q;
    logic [KEY_W-1:0] k_q;
    logic [RSP_W-1:0] r_q;
    logic             set_e;
    logic             clr_e;

    assign set_e = wr_en  && (wr_idx  == IDX_W'(e));
    assign clr_e = clr_en && (clr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (set_e || clr_e) begin
        v_q <= set_e;
      end
    end

    always_ff @(posedge clk) begin
      if (set_e) begin
        k_q <= wr_key;
        r_q <= wr_rsp;
      end
    end

    assign vld_vec[e] = v_q;
    assign key_vec[e] = k_q;
    assign rsp_vec[e] = r_q;
  end

  always_comb begin
    rd_vld = vld_vec[rd_idx];
    rd_key = key_vec[rd_idx];
    rd_rsp = rsp_vec[rd_idx];
  end
endmodule

// File: rtl/kvt_reply_pack.sv
module kvt_reply_pack
  import kvt_pkg::*;
(
  input  logic [7:0]         status,
  input  logic [FILL_W-1:0]  fill,
  output logic [REPLY_W-1:0] word
);
  always_comb begin
    word = {fill, status};
  end
endmodule

// File: rtl/kv_cmd_table.sv
module kv_cmd_table
  import kvt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int KEY_W = 32,
  parameter int RSP_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CMD_W = 8 + byte_span(KEY_W) + byte_span(RSP_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_data,
  output logic               rpl_valid,
  input  logic               rpl_ready,
  output logic [REPLY_W-1:0] rpl_data
);
  typedef enum logic [1:0] {F_IDLE, F_SCAN, F_EXEC, F_REPLY} fsm_e;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  // command fields
  logic [7:0]       in_op;
  logic             in_known;
  logic [KEY_W-1:0] in_key;
  logic [RSP_W-1:0] in_rsp;

  kvt_cmd_unpack #(.KEY_W(KEY_W), .RSP_W(RSP_W)) u_unpack (
    .cmd_word     (cmd_data),
    .opcode       (in_op),
    .opcode_known (in_known),
    .key          (in_key),
    .rsp          (in_rsp)
  );

  // state
  fsm_e              st_q, st_d;
  logic [7:0]        op_q, op_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [RSP_W-1:0]  rsp_q, rsp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              hit_q, hit_d;
  logic [IDX_W-1:0]  hit_idx_q, hit_idx_d;
  logic              free_q, free_d;
  logic [IDX_W-1:0]  free_idx_q, free_idx_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [REPLY_W-1:0] rpl_q, rpl_d;
  logic              ld_cmd, ld_rpl;

  // store ports
  logic             wr_en, clr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             rd_vld;
  logic [KEY_W-1:0] rd_key;
  logic [RSP_W-1:0] unused_rd_rsp;
  logic             entry_hit;

  kvt_entry_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .RSP_W(RSP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_key  (key_q),
    .wr_rsp  (rsp_q),
    .clr_en  (clr_en),
    .clr_idx (hit_idx_q),
    .rd_idx  (idx_q),
    .rd_vld  (rd_vld),
    .rd_key  (rd_key),
    .rd_rsp  (unused_rd_rsp)
  );

  assign entry_hit = rd_vld && (rd_key == key_q);

  // reply packing
  logic [7:0]         res_code;
  logic [FILL_W-1:0]  res_fill;
  logic [REPLY_W-1:0] res_word;

  kvt_reply_pack u_pack (
    .status (res_code),
    .fill   (res_fill),
    .word   (res_word)
  );

  // next state
  always_comb begin
    st_d       = st_q;
    op_d       = op_q;
    key_d      = key_q;
    rsp_d      = rsp_q;
    idx_d      = idx_q;
    hit_d      = hit_q;
    hit_idx_d  = hit_idx_q;
    free_d     = free_q;
    free_idx_d = free_idx_q;
    fill_d     = fill_q;
    rpl_d      = rpl_q;
    ld_cmd     = 1'b0;
    ld_rpl     = 1'b0;
    wr_en      = 1'b0;
    wr_idx     = free_idx_q;
    clr_en     = 1'b0;
    res_code   = RES_BUSY;
    res_fill   = fill_q;

    unique case (st_q)
      F_IDLE: begin
        if (cmd_valid) begin
          ld_cmd = 1'b1;
          op_d   = in_op;
          key_d  = in_key;
          rsp_d  = in_rsp;
          idx_d  = '0;
          hit_d  = 1'b0;
          free_d = 1'b0;
          if (in_known) begin
            st_d = F_SCAN;
          end else begin
            res_code = RES_BUSY;
            ld_rpl   = 1'b1;
            st_d     = F_REPLY;
          end
        end
      end
      F_SCAN: begin
        if (entry_hit) begin
          hit_d     = 1'b1;
          hit_idx_d = idx_q;
          st_d      = F_EXEC;
        end else begin
          if (!rd_vld && !free_q) begin
            free_d     = 1'b1;
            free_idx_d = idx_q;
          end
          if (idx_q == IDX_W'(DEPTH - 1)) st_d = F_EXEC;
          else                            idx_d = idx_q + IDX_W'(1);
        end
      end
      F_EXEC: begin
        ld_rpl = 1'b1;
        st_d   = F_REPLY;
        unique case (op_q)
          OPC_INSERT: begin
            if (hit_q) begin
              res_code = RES_DUP;
            end else if (free_q) begin
              wr_en    = 1'b1;
              fill_d   = fill_q + FILL_W'(1);
              res_code = RES_OK;
            end else begin
              res_code = RES_FULL;
            end
          end
          OPC_UPDATE: begin
            wr_idx   = hit_idx_q;
            wr_en    = hit_q;
            res_code = hit_q ? RES_OK : RES_MISSING;
          end
          OPC_DELETE: begin
            clr_en   = hit_q;
            if (hit_q) fill_d = fill_q - FILL_W'(1);
            res_code = hit_q ? RES_OK : RES_MISSING;
          end
          default: begin
            res_code = hit_q ? RES_OK : RES_MISSING;
          end
        endcase
        res_fill = fill_d;
      end
      F_REPLY: begin
        if (rpl_ready) st_d = F_IDLE;
      end
      default: st_d = F_IDLE;
    endcase

    if (ld_rpl) rpl_d = res_word;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q       <= F_IDLE;
      idx_q      <= '0;
      hit_q      <= 1'b0;
      hit_idx_q  <= '0;
      free_q     <= 1'b0;
      free_idx_q <= '0;
      fill_q     <= '0;
      rpl_q      <= '0;
    end else begin
      st_q       <= st_d;
      idx_q      <= idx_d;
      hit_q      <= hit_d;
      hit_idx_q  <= hit_idx_d;
      free_q     <= free_d;
      free_idx_q <= free_idx_d;
      fill_q     <= fill_d;
      if (ld_rpl) rpl_q <= rpl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_cmd) begin
      op_q  <= op_d;
      key_q <= key_d;
      rsp_q <= rsp_d;
    end
  end

  assign cmd_ready = (st_q == F_IDLE) && rst_i_n;
  assign rpl_valid = (st_q == F_REPLY);
  assign rpl_data  = rpl_q;
endmodule

// File: rtl/kvt_checker.sv
module kvt_checker
  import kvt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               rpl_valid,
  input logic               rpl_ready,
  input logic [REPLY_W-1:0] rpl_data
);
  // R9
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_valid && !rpl_ready) |=> (rpl_valid && $stable(rpl_data)));

  // R1
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> !cmd_ready);

  // R1
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> (rpl_data[23:8] <= 16'(DEPTH)));

  // R8
  status_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> (rpl_data[7:0] <= 8'h04));
endmodule

bind kv_cmd_table kvt_checker #(.DEPTH(DEPTH)) u_kvt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rpl_valid (rpl_valid),
  .rpl_ready (rpl_ready),
  .rpl_data  (rpl_data)
);

// File: tb/tb_kv_cmd_table.sv
module tb_kv_cmd_table;
  localparam int DEPTH = 4;
  localparam int KEY_W = 12;
  localparam int RSP_W = 5;
  localparam int CMD_W = 8 + 8 * ((KEY_W + 7) / 8) + 8 * ((RSP_W + 7) / 8);
  localparam int RSP_POS = 8 + 8 * ((KEY_W + 7) / 8);

  logic             clk;
  logic             rst_n;
  logic             cmd_valid;
  logic             cmd_ready;
  logic [CMD_W-1:0] cmd_data;
  logic             rpl_valid;
  logic             rpl_ready;
  logic [23:0]      rpl_data;

  kv_cmd_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .RSP_W(RSP_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .rpl_valid (rpl_valid),
    .rpl_ready (rpl_ready),
    .rpl_data  (rpl_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  bit stall_mode = 1'b0;
  logic [31:0] cyc = '0;

  always @(posedge clk) cyc <= cyc + 32'd1;
  assign rpl_ready = stall_mode ? (cyc[1:0] != 2'b00) : 1'b1;

  // reference model
  logic [KEY_W-1:0] m_key [DEPTH];
  bit               m_vld [DEPTH];
  int               m_fill = 0;
  logic [23:0]      exp_q [$];
  string            req_q [$];

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find_key(input logic [KEY_W-1:0] k);
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_key[i] == k) return i;
    return -1;
  endfunction

  task automatic model(input logic [7:0] op, input logic [KEY_W-1:0] k);
    int pos;
    logic [7:0] st;
    string req;
    pos = find_key(k);
    case (op)
      8'h00: begin
        req = "R4";
        if (pos >= 0) st = 8'h03;
        else if (m_fill == DEPTH) st = 8'h01;
        else begin
          st = 8'h00;
          for (int i = 0; i < DEPTH; i++) begin
            if (!m_vld[i]) begin
              m_vld[i] = 1'b1;
              m_key[i] = k;
              break;
            end
          end
          m_fill++;
        end
      end
      8'h01: begin req = "R5"; st = (pos >= 0) ? 8'h00 : 8'h02; end
      8'h02: begin
        req = "R6";
        if (pos >= 0) begin
          m_vld[pos] = 1'b0;
          m_fill--;
          st = 8'h00;
        end else st = 8'h02;
      end
      8'h03: begin req = "R7"; st = (pos >= 0) ? 8'h00 : 8'h02; end
      default: begin req = "R8"; st = 8'h04; end
    endcase
    exp_q.push_back({16'(m_fill), st});
    req_q.push_back(req);
  endtask

  // R2: field positions used to build the command word
  task automatic send(input logic [7:0] op, input logic [KEY_W-1:0] k, input logic [RSP_W-1:0] r);
    @(negedge clk);
    cmd_data = '0;
    cmd_data[7:0] = op;
    cmd_data[8 +: KEY_W] = k;
    cmd_data[RSP_POS +: RSP_W] = r;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    model(op, k);
    sent++;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data = '1;
  endtask

  // per-clock monitor
  logic        prev_hold = 1'b0;
  logic [23:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) chk(rpl_valid && rpl_data == prev_data, "R9 hold", rpl_data, prev_data);
      if (rpl_valid) chk(!cmd_ready, "R1 ready low while reply pending", {23'd0, cmd_ready}, 24'd0);
      if (rpl_valid && rpl_ready) begin
        got++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected reply", rpl_data, 24'd0);
        end else begin
          logic [23:0] e;
          string rq;
          e = exp_q.pop_front();
          rq = req_q.pop_front();
          chk(rpl_data == e, {rq, "/R3 reply"}, rpl_data, e);
        end
      end
      prev_hold = rpl_valid && !rpl_ready;
      prev_data = rpl_data;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(cmd_ready === 1'b1, "R10 cmd_ready after reset", {23'd0, cmd_ready}, 24'd1);
    chk(rpl_valid === 1'b0, "R10 rpl_valid after reset", {23'd0, rpl_valid}, 24'd0);

    send(8'h03, 12'h005, 5'h01);   // R10 empty: get misses, fill 0
    send(8'h00, 12'h005, 5'h11);   // R4 insert
    send(8'h00, 12'h005, 5'h12);   // R4 duplicate
    send(8'h01, 12'h005, 5'h1F);   // R5 update present
    send(8'h01, 12'h009, 5'h02);   // R5 update absent
    send(8'h03, 12'h005, 5'h00);   // R7 get present
    send(8'h02, 12'h009, 5'h00);   // R6 delete absent
    stall_mode = 1'b1;
    send(8'h00, 12'hFFF, 5'h03);   // R4
    send(8'h03, 12'h7FF, 5'h00);   // R7 top-bit difference misses
    send(8'h00, 12'h7FF, 5'h04);   // R4
    send(8'h00, 12'h0A0, 5'h05);   // R4 now full
    send(8'h00, 12'h0B0, 5'h06);   // R4 full
    send(8'h07, 12'h0B0, 5'h06);   // R8 unknown opcode
    send(8'h80, 12'h005, 5'h06);   // R8 unknown opcode
    send(8'h03, 12'h0B0, 5'h00);   // R8 nothing stored by unknown opcode
    send(8'h02, 12'hFFF, 5'h00);   // R6 delete present
    send(8'h03, 12'hFFF, 5'h00);   // R6 deleted key reads absent
    send(8'h00, 12'h0B0, 5'h07);   // R6 freed slot reused
    stall_mode = 1'b0;
    send(8'h02, 12'h005, 5'h00);   // R6
    send(8'h02, 12'h7FF, 5'h00);
    send(8'h02, 12'h0A0, 5'h00);
    send(8'h02, 12'h0B0, 5'h00);   // R6 fill back to zero
    send(8'h02, 12'h0B0, 5'h00);   // R6 absent again
    send(8'h03, 12'h000, 5'h00);   // R7 get on empty

    repeat (40) @(negedge clk);
    chk(sent == got, "R9 one reply per command", 24'(got), 24'(sent));
    chk(cmd_ready === 1'b1 && rpl_valid === 1'b0, "R1 idle after last reply",
        {22'd0, cmd_ready, rpl_valid}, 24'd2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule